// File: doc/BRIEF.md
# Periodic Interrupt Down-Timer with Compare

This block is a 32-bit down-counter behind a small word-addressed register file. Software picks one of three tick-enable inputs (or none) as the count source and divides it by a 12-bit prescaler. It then chooses whether the counter reloads from a programmed load value or wraps to all-ones when it expires. A compare register and a sticky status flag give a level interrupt when the count lands on the compare value.

A control write can start the counter from a known value, resume it where it stopped, or perform a soft reset. The soft reset spares the prescaler, clock-source and mode fields. A load write can optionally overwrite the running count at once. The interrupt flag is cleared by writing 1 to status bit 0.

Top module: `pit_down_timer`

## Requirements
- R1: Word offsets are control=0, status=1, load=2, compare=3, count=4 (read-only). Reads of any other offset return 0, and writes to them change no register.
- R2: Control holds bits 25:0 only: en=0, start_mode=1, cmp_ie=2, reload=3, divider=15:4, soft_rst=16, ovw_now=17, four low-power enables=21:18, clock select=25:24. Bits 31:26 always read 0.
- R3: After hard reset or soft reset, status reads 0, load reads 0xFFFFFFFF, compare reads 0 and count reads 0. Hard reset also clears control.
- R4: A control write with bit 16 set stores the written value with bits 0, 1, 16 and 21:18 cleared, keeping every other field. Control then reads back with bit 16 at 0.
- R5: Clock select 0 gives no ticks. Select codes 1, 2 and 3 take tick input bits 0, 1 and 2 respectively.
- R6: The counter steps once per (divider+1) ticks of the selected input. Every control write restarts the divider phase.
- R7: A step from count 0 loads the load register when reload=1, and 0xFFFFFFFF when reload=0. Any other step decrements by one.
- R8: A control write that changes en from 0 to 1 with start_mode=1 sets the count to the load value (reload=1) or 0xFFFFFFFF (reload=0). With start_mode=0 the count is kept. While en=0 the count does not step.
- R9: A load write with ovw_now=1 also sets the count to the written value in the next cycle. With ovw_now=0 the count is unchanged.
- R10: A step whose new count equals compare sets status bit 0.
- R11: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R12: irq_o is 1 exactly when the status flag is 1 and cmp_ie=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 3 | Tick-enable inputs from the three sources |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench lets a reload-mode count run through zero. A design that reloaded from all-ones, or stopped at zero, would show the wrong count after the wrap. The free-run case uses a load value of 2, so a design that reloaded from load would read 2 and not 0xFFFFFFFF. The bench enables with start_mode=0 after a pause; a design that always restarted would lose the held count. With divider 3 it counts exactly four source ticks to one step, which catches an off-by-one divider. Write-0-to-status, unmapped writes and the bits spared by soft reset are read back through the register file. A design that cleared the flag or disturbed a field there shows a wrong value.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 12;
    localparam int NSRC   = 3;
    localparam int SEL_W  = $clog2(NSRC + 1);
    localparam int CTRL_W = 26;

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;    // 25:24
        logic [1:0]       spare;      // 23:22
        logic             stop_en;    // 21
        logic             doze_en;    // 20
        logic             wait_en;    // 19
        logic             dbg_en;     // 18
        logic             ovw_now;    // 17
        logic             soft_rst;   // 16
        logic [PRE_W-1:0] div;        // 15:4
        logic             rld;        // 3
        logic             cmp_ie;     // 2
        logic             start_mode; // 1
        logic             en;         // 0
    } ctrl_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_LOAD = 3'd2,
        A_CMP  = 3'd3,
        A_CNT  = 3'd4
    } reg_addr_e;

    function automatic ctrl_t spare_on_soft_reset(ctrl_t c);
        ctrl_t r;
        r            = c;
        r.en         = 1'b0;
        r.start_mode = 1'b0;
        r.soft_rst   = 1'b0;
        r.dbg_en     = 1'b0;
        r.wait_en    = 1'b0;
        r.doze_en    = 1'b0;
        r.stop_en    = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/pit_tick_gen.sv
module pit_tick_gen
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;
    logic             sel_tick;

    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i + 1)) sel_tick = src_tick[i];
        end
    end

    assign tick = run && !restart && sel_tick && (phase_q == div);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase_q <= '0;
        end else if (sel_tick) begin
            phase_q <= (phase_q == div) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              zero,
    input  logic              force_ld,
    input  logic [DATA_W-1:0] force_val,
    input  logic              start,
    input  logic [DATA_W-1:0] start_val,
    input  logic              tick,
    input  logic              rld,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] cnt,
    output logic              hit
);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] step_val;
    logic              stepping;

    assign step_val = (cnt_q == '0) ? (rld ? load_val : ALL_ONES) : cnt_q - 1'b1;
    assign stepping = tick && !zero && !force_ld && !start;
    assign hit      = stepping && (step_val == cmp_val);
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || zero)   cnt_q <= '0;
        else if (force_ld) cnt_q <= force_val;
        else if (start)    cnt_q <= start_val;
        else if (stepping) cnt_q <= step_val;
    end

endmodule

// File: rtl/pit_down_timer.sv
module pit_down_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_tick,
    output logic              irq_o
);

    ctrl_t             ctrl_q;
    ctrl_t             wr_val;
    ctrl_t             ctrl_next;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cmp_q;
    logic              flag_q;
    logic [DATA_W-1:0] cnt_w;
    logic              cmp_hit;
    logic              tick;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic              soft_evt, start_evt;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_load = bus_wr && (bus_addr == A_LOAD);
    assign wr_cmp  = bus_wr && (bus_addr == A_CMP);

    assign wr_val    = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign soft_evt  = wr_ctrl && wr_val.soft_rst;
    assign ctrl_next = wr_val.soft_rst ? spare_on_soft_reset(wr_val) : wr_val;
    assign start_evt = wr_ctrl && !soft_evt && !ctrl_q.en && wr_val.en && wr_val.start_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= ALL_ONES;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_next;
            if (soft_evt) begin
                load_q <= ALL_ONES;
                cmp_q  <= '0;
            end else begin
                if (wr_load) load_q <= bus_wdata;
                if (wr_cmp)  cmp_q  <= bus_wdata;
            end
            if (soft_evt)                    flag_q <= 1'b0;
            else if (cmp_hit)                flag_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    pit_tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_ctrl),
        .run      (ctrl_q.en),
        .sel      (ctrl_q.clk_sel),
        .src_tick (src_tick),
        .div      (ctrl_q.div),
        .tick     (tick)
    );

    pit_count_core u_core (
        .clk       (clk),
        .rst       (rst),
        .zero      (soft_evt),
        .force_ld  (wr_load && ctrl_q.ovw_now),
        .force_val (bus_wdata),
        .start     (start_evt),
        .start_val (wr_val.rld ? load_q : ALL_ONES),
        .tick      (tick),
        .rld       (ctrl_q.rld),
        .load_val  (load_q),
        .cmp_val   (cmp_q),
        .cnt       (cnt_w),
        .hit       (cmp_hit)
    );

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_STAT:  bus_rdata = DATA_W'(flag_q);
            A_LOAD:  bus_rdata = load_q;
            A_CMP:   bus_rdata = cmp_q;
            A_CNT:   bus_rdata = cnt_w;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = flag_q && ctrl_q.cmp_ie;

endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              flag,
    input logic              en,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] load,
    input logic              swr_q,
    input logic              hit
);

    // R10
    cmp_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);

    // R11
    w1c_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd1 && bus_wdata[0] && !hit) |=> !flag);

    // R4
    soft_reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[16]) |=> (cnt == '0 && load == ALL_ONES && !swr_q && !flag));

    // R8
    halted_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !bus_wr) |=> $stable(cnt));

    // R12
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(hit) || $past(bus_wr && bus_addr == 3'd0)));

    // R2
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> (bus_rdata[31:26] == 6'd0));

endmodule

bind pit_down_timer pit_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .flag      (flag_q),
    .en        (ctrl_q.en),
    .cnt       (cnt_w),
    .load      (load_q),
    .swr_q     (ctrl_q.soft_rst),
    .hit       (cmp_hit)
);

// File: tb/pit_down_timer_test.sv
`timescale 1ns/1ps
module pit_down_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  src_tick = '0;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pit_down_timer uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .irq_o(irq_o)
    );

    // op: 0 write, 1 read-compare, 2 tick (addr = source bit, data = count), 3 irq compare
    // fields: {req[3:0], op[1:0], addr[2:0], data[31:0], exp[31:0]}
    localparam logic [72:0] VEC [0:62] = '{
        {4'd3, 2'd1, 3'd2, 32'd0, 32'hFFFFFFFF},        // R3 load reset
        {4'd3, 2'd1, 3'd3, 32'd0, 32'd0},               // R3 compare reset
        {4'd3, 2'd1, 3'd4, 32'd0, 32'd0},               // R3 count reset
        {4'd9, 2'd0, 3'd2, 32'd100, 32'd0},             // R9 load, no overwrite
        {4'd9, 2'd1, 3'd4, 32'd0, 32'd0},               // R9 count unchanged
        {4'd8, 2'd0, 3'd0, 32'h0100000B, 32'd0},        // R8 enable, reload start
        {4'd8, 2'd1, 3'd4, 32'd0, 32'd100},             // R8 starts at load
        {4'd1, 2'd1, 3'd0, 32'd0, 32'h0100000B},        // R1 control read
        {4'd6, 2'd2, 3'd0, 32'd10, 32'd0},              // R6 ten ticks
        {4'd6, 2'd1, 3'd4, 32'd0, 32'd90},              // R6
        {4'd10, 2'd0, 3'd3, 32'd85, 32'd0},             // R10 compare 85
        {4'd10, 2'd2, 3'd0, 32'd5, 32'd0},              // R10
        {4'd10, 2'd1, 3'd4, 32'd0, 32'd85},             // R10
        {4'd10, 2'd1, 3'd1, 32'd0, 32'd1},              // R10 flag set
        {4'd12, 2'd3, 3'd0, 32'd0, 32'd0},              // R12 irq masked
        {4'd11, 2'd0, 3'd1, 32'd0, 32'd0},              // R11 write 0
        {4'd11, 2'd1, 3'd1, 32'd0, 32'd1},              // R11 flag kept
        {4'd11, 2'd0, 3'd1, 32'd1, 32'd0},              // R11 write 1
        {4'd11, 2'd1, 3'd1, 32'd0, 32'd0},              // R11 flag cleared
        {4'd7, 2'd2, 3'd0, 32'd86, 32'd0},              // R7 run through zero
        {4'd7, 2'd1, 3'd4, 32'd0, 32'd100},             // R7 reload from load
        {4'd12, 2'd0, 3'd0, 32'h0100000F, 32'd0},       // R12 irq enable
        {4'd12, 2'd2, 3'd0, 32'd15, 32'd0},             // R12
        {4'd12, 2'd3, 3'd0, 32'd0, 32'd1},              // R12 irq high
        {4'd12, 2'd0, 3'd1, 32'd1, 32'd0},              // R12
        {4'd12, 2'd3, 3'd0, 32'd0, 32'd0},              // R12 irq low
        {4'd9, 2'd0, 3'd0, 32'h0102000F, 32'd0},        // R9 overwrite on
        {4'd9, 2'd0, 3'd2, 32'd50, 32'd0},              // R9
        {4'd9, 2'd1, 3'd4, 32'd0, 32'd50},              // R9 count overwritten
        {4'd8, 2'd0, 3'd0, 32'h0100000E, 32'd0},        // R8 disable
        {4'd8, 2'd2, 3'd0, 32'd3, 32'd0},               // R8
        {4'd8, 2'd1, 3'd4, 32'd0, 32'd50},              // R8 halted
        {4'd8, 2'd0, 3'd0, 32'h01000003, 32'd0},        // R8 free-run start
        {4'd8, 2'd1, 3'd4, 32'd0, 32'hFFFFFFFF},        // R8
        {4'd7, 2'd0, 3'd0, 32'h01020003, 32'd0},        // R7
        {4'd7, 2'd0, 3'd2, 32'd2, 32'd0},               // R7
        {4'd7, 2'd2, 3'd0, 32'd3, 32'd0},               // R7
        {4'd7, 2'd1, 3'd4, 32'd0, 32'hFFFFFFFF},        // R7 free-run wrap
        {4'd8, 2'd2, 3'd0, 32'd2, 32'd0},               // R8
        {4'd8, 2'd0, 3'd0, 32'h01000000, 32'd0},        // R8
        {4'd8, 2'd0, 3'd0, 32'h01000001, 32'd0},        // R8 resume
        {4'd8, 2'd1, 3'd4, 32'd0, 32'hFFFFFFFD},        // R8
        {4'd6, 2'd0, 3'd0, 32'h01000031, 32'd0},        // R6 divider 3
        {4'd6, 2'd2, 3'd0, 32'd4, 32'd0},               // R6
        {4'd6, 2'd1, 3'd4, 32'd0, 32'hFFFFFFFC},        // R6
        {4'd6, 2'd2, 3'd0, 32'd3, 32'd0},               // R6
        {4'd6, 2'd1, 3'd4, 32'd0, 32'hFFFFFFFC},        // R6
        {4'd6, 2'd2, 3'd0, 32'd1, 32'd0},               // R6
        {4'd6, 2'd1, 3'd4, 32'd0, 32'hFFFFFFFB},        // R6
        {4'd5, 2'd0, 3'd0, 32'h02000001, 32'd0},        // R5 select 2
        {4'd5, 2'd2, 3'd0, 32'd3, 32'd0},               // R5
        {4'd5, 2'd1, 3'd4, 32'd0, 32'hFFFFFFFB},        // R5 other input ignored
        {4'd5, 2'd2, 3'd1, 32'd2, 32'd0},               // R5
        {4'd5, 2'd1, 3'd4, 32'd0, 32'hFFFFFFF9},        // R5
        {4'd5, 2'd0, 3'd0, 32'h00000001, 32'd0},        // R5 select 0
        {4'd5, 2'd2, 3'd0, 32'd2, 32'd0},               // R5
        {4'd5, 2'd1, 3'd4, 32'd0, 32'hFFFFFFF9},        // R5 no ticks
        {4'd5, 2'd0, 3'd0, 32'h03000001, 32'd0},        // R5 select 3
        {4'd5, 2'd2, 3'd2, 32'd1, 32'd0},               // R5
        {4'd5, 2'd1, 3'd4, 32'd0, 32'hFFFFFFF8},        // R5
        {4'd1, 2'd0, 3'd5, 32'd123, 32'd0},             // R1 unmapped write
        {4'd1, 2'd1, 3'd5, 32'd0, 32'd0},               // R1 unmapped read
        {4'd1, 2'd1, 3'd2, 32'd0, 32'd2}                // R1 load untouched
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_tick = 3'b001 << idx;
        end
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic chk_irq(input int req, input logic exp);
        @(negedge clk);
        #1;
        check(req, {31'd0, irq_o}, {31'd0, exp});
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(3, 3'd1, 32'd0);   // R3 status after reset
        rd(3, 3'd0, 32'd0);   // R3 control after reset
        for (int i = 0; i < 63; i++) begin
            case (VEC[i][68:67])
                2'd0: wr(VEC[i][66:64], VEC[i][63:32]);
                2'd1: rd(int'(VEC[i][72:69]), VEC[i][66:64], VEC[i][31:0]);
                2'd2: ticks(int'(VEC[i][66:64]), int'(VEC[i][63:32]));
                default: chk_irq(int'(VEC[i][72:69]), VEC[i][0]);
            endcase
        end
        // R10 flag from a hit, then soft reset clears it (R3, R4)
        wr(3'd3, 32'hFFFFFFF7);
        ticks(2, 1);
        rd(10, 3'd1, 32'd1);
        wr(3'd0, 32'h03FFFFFF);
        rd(4, 3'd0, 32'h03C2FFFC);      // R4 spared fields, bit 16 self-clears
        rd(3, 3'd1, 32'd0);             // R3
        rd(3, 3'd2, 32'hFFFFFFFF);      // R3
        rd(3, 3'd3, 32'd0);             // R3
        rd(3, 3'd4, 32'd0);             // R3
        wr(3'd0, 32'hFC000005);
        rd(2, 3'd0, 32'h00000005);      // R2 upper bits dropped
        // hard reset (R3)
        wr(3'd2, 32'd7);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(3, 3'd2, 32'hFFFFFFFF);
        rd(3, 3'd0, 32'd0);
        rd(3, 3'd4, 32'd0);
        chk_irq(12, 1'b0);              // R12
        done = 1'b1;
        finish_run();
    end

endmodule